// File: doc/BRIEF.md
# Compressive Sensing Acquisition Sequencer

This block sequences the digital side of a compressive-sensing image capture for a pixel array in which every pixel holds one ±1 weight bit. The weights form a long chain. On an observation's first start the sequencer fills that chain one bit per cycle from a pseudo-random serial source. It then runs a set of measurements. Each measurement is a pair of cycles: one cycle pushes a single fresh weight into the chain, and the next cycle strobes the converter and raises the fast common-mode bias. The bias is high only while the sample strobe is high.

Later observations skip the full fill. They first re-scramble the stored weights by rotating the array cylindrically. The horizontal rotation is a random number of steps and the vertical rotation is a second random number of steps. Each step count comes from its own pseudo-random source and lies in the range 0 to 15. After the scramble, the same measurement pairs follow. The measurement count is taken from an input when start is accepted. The array itself, the analog front end and the converter lie outside this block.

Top module: `cs_acq_seq`

## Requirements
- R1: After reset, busy, in_init, ss_en, hs_en, vs_en, adc_sample and cmfb_fast are all low, and h_count and v_count are 0.
- R2: The first accepted start opens a fill phase in which ss_en and in_init are both high for exactly ROWS×COLS consecutive cycles. The serial source is a 16-bit Fibonacci register with seed 0xACE1. Its next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}. coef_bit is s[0], and the register advances only in cycles where ss_en is high.
- R3: After the fill, or after the scramble, the block runs M insert/sample pairs. The insert cycle has ss_en high and in_init low. The sample cycle that follows has adc_sample high. busy stays high through the last sample cycle and is low in the cycle after it.
- R4: cmfb_fast is high in exactly the cycles in which adc_sample is high.
- R5: Every accepted start after the first skips the fill. It sets h_count and v_count to the low 4 bits of two 8-bit Fibonacci registers. Both registers use next state {s[6:0], s[7]^s[5]^s[4]^s[3]}, with seeds 0x01 and 0xB4, and each advances once per such start. The block then holds hs_en high for h_count cycles, then vs_en high for v_count cycles, then runs the R3 pairs.
- R6: A step count of 0 skips its rotation phase entirely: no enable pulse occurs and the next phase begins at once.
- R7: meas_count is sampled only when a start is accepted. A start while busy, or a change of meas_count during an observation, changes neither the outputs nor the sequence.
- R8: A start with meas_count equal to 0 is ignored. The block stays idle and no source advances.
- R9: At most one of ss_en, hs_en, vs_en and adc_sample is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one observation; accepted only while idle |
| meas_count | input | MW | Number of measurements M for the observation |
| ss_en | output | 1 | Serial weight shift enable |
| coef_bit | output | 1 | Serial weight bit entering the chain |
| hs_en | output | 1 | Horizontal one-step rotation enable |
| vs_en | output | 1 | Vertical one-step rotation enable |
| adc_sample | output | 1 | Converter sample strobe |
| cmfb_fast | output | 1 | Fast common-mode bias enable |
| h_count | output | SCW | Horizontal step count of the current observation |
| v_count | output | SCW | Vertical step count of the current observation |
| busy | output | 1 | Observation in progress |
| in_init | output | 1 | Full fill phase active |

## Verification
The hardest case to reach is a rotation phase skipped because its step count is zero. The step counts come from free-running pseudo-random sources that advance only once per observation, so the ports offer no way to force a zero. The stimulus therefore runs more than a full period of the 8-bit sources, 256 short observations on a 4×4 array. This guarantees that both the horizontal and the vertical sources present a zero low nibble at least once. The bench tallies those zero counts and checks the enable waveform cycle by cycle around each one. Starts while busy, and changes to the measurement count in mid-observation, are mixed into the same run.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_INIT   = 3'd1,
        PH_SCR_H  = 3'd2,
        PH_SCR_V  = 3'd3,
        PH_INSERT = 3'd4,
        PH_MEAS   = 3'd5
    } phase_t;
endpackage

// File: rtl/cs_lfsr.sv
module cs_lfsr #(
    parameter int W = 16,
    parameter int OUT_W = 1,
    parameter logic [W-1:0] TAPS = '1,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [OUT_W-1:0] value
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (adv) state_d = {state_q[W-2:0], ^(state_q & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign value = state_q[OUT_W-1:0];

    assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
    assert_lfsr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q));
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
    import cs_seq_pkg::*;
#(
    parameter int CELLS = 65536,
    parameter int MW = 16,
    parameter int SCW = 4,
    parameter int CW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [MW-1:0]  meas_count,
    input  logic [SCW-1:0] h_val,
    input  logic [SCW-1:0] v_val,
    output logic           shift_take,
    output logic           ss_en,
    output logic           hs_en,
    output logic           vs_en,
    output logic           adc_sample,
    output logic           cmfb_fast,
    output logic [SCW-1:0] h_count,
    output logic [SCW-1:0] v_count,
    output logic           busy,
    output logic           in_init
);
    typedef struct packed {
        phase_t         ph;
        logic [CW-1:0]  cnt;
        logic [MW-1:0]  mleft;
        logic [SCW-1:0] hc;
        logic [SCW-1:0] vc;
        logic           seeded;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        shift_take = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start && meas_count != '0) begin
                    s_d.mleft = meas_count - 1'b1;
                    if (!s_q.seeded) begin
                        s_d.ph  = PH_INIT;
                        s_d.cnt = CW'(CELLS - 1);
                    end else begin
                        shift_take = 1'b1;
                        s_d.hc = h_val;
                        s_d.vc = v_val;
                        if (h_val != '0) begin
                            s_d.ph  = PH_SCR_H;
                            s_d.cnt = CW'(h_val) - 1'b1;
                        end else if (v_val != '0) begin
                            s_d.ph  = PH_SCR_V;
                            s_d.cnt = CW'(v_val) - 1'b1;
                        end else begin
                            s_d.ph = PH_INSERT;
                        end
                    end
                end
            end
            PH_INIT: begin
                if (s_q.cnt == '0) begin
                    s_d.seeded = 1'b1;
                    s_d.ph = PH_INSERT;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_SCR_H: begin
                if (s_q.cnt == '0) begin
                    if (s_q.vc != '0) begin
                        s_d.ph  = PH_SCR_V;
                        s_d.cnt = CW'(s_q.vc) - 1'b1;
                    end else begin
                        s_d.ph = PH_INSERT;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_SCR_V: begin
                if (s_q.cnt == '0) s_d.ph = PH_INSERT;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            PH_INSERT: s_d.ph = PH_MEAS;
            PH_MEAS: begin
                if (s_q.mleft == '0) begin
                    s_d.ph = PH_IDLE;
                end else begin
                    s_d.mleft = s_q.mleft - 1'b1;
                    s_d.ph = PH_INSERT;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ss_en      = (s_q.ph == PH_INIT) || (s_q.ph == PH_INSERT);
    assign in_init    = (s_q.ph == PH_INIT);
    assign hs_en      = (s_q.ph == PH_SCR_H);
    assign vs_en      = (s_q.ph == PH_SCR_V);
    assign adc_sample = (s_q.ph == PH_MEAS);
    assign cmfb_fast  = (s_q.ph == PH_MEAS);
    assign busy       = (s_q.ph != PH_IDLE);
    assign h_count    = s_q.hc;
    assign v_count    = s_q.vc;

    assert_single_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ss_en, hs_en, vs_en, adc_sample}));
    assert_insert_then_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_en && !in_init) |=> adc_sample);
    assert_sample_after_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sample |-> $past(ss_en));
    assert_fast_bias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmfb_fast == adc_sample);
    assert_counts_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(h_count) && $stable(v_count)));
    assert_zero_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && meas_count == '0) |=> !busy);
endmodule

// File: rtl/cs_acq_seq.sv
module cs_acq_seq #(
    parameter int ROWS = 256,
    parameter int COLS = 256,
    parameter int MW = 16,
    parameter int SCW = 4,
    parameter int SER_W = 16,
    parameter logic [SER_W-1:0] SER_TAPS = 16'hB400,
    parameter logic [SER_W-1:0] SER_SEED = 16'hACE1,
    parameter int SHL_W = 8,
    parameter logic [SHL_W-1:0] SH_TAPS = 8'hB8,
    parameter logic [SHL_W-1:0] H_SEED = 8'h01,
    parameter logic [SHL_W-1:0] V_SEED = 8'hB4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [MW-1:0]  meas_count,
    output logic           ss_en,
    output logic           coef_bit,
    output logic           hs_en,
    output logic           vs_en,
    output logic           adc_sample,
    output logic           cmfb_fast,
    output logic [SCW-1:0] h_count,
    output logic [SCW-1:0] v_count,
    output logic           busy,
    output logic           in_init
);
    localparam int CELLS = ROWS * COLS;
    localparam int CW = ($clog2(CELLS) > SCW) ? $clog2(CELLS) : SCW;

    logic           shift_take;
    logic [SCW-1:0] sh_val [2];

    cs_lfsr #(.W(SER_W), .OUT_W(1), .TAPS(SER_TAPS), .SEED(SER_SEED)) u_ser (
        .clk(clk), .rst_n(rst_n), .adv(ss_en), .value(coef_bit)
    );

    for (genvar g = 0; g < 2; g++) begin : g_shift_src
        cs_lfsr #(.W(SHL_W), .OUT_W(SCW), .TAPS(SH_TAPS),
                  .SEED(g == 0 ? H_SEED : V_SEED)) u_sh (
            .clk(clk), .rst_n(rst_n), .adv(shift_take), .value(sh_val[g])
        );
    end

    cs_seq_fsm #(.CELLS(CELLS), .MW(MW), .SCW(SCW), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .meas_count(meas_count),
        .h_val(sh_val[0]), .v_val(sh_val[1]), .shift_take(shift_take),
        .ss_en(ss_en), .hs_en(hs_en), .vs_en(vs_en), .adc_sample(adc_sample),
        .cmfb_fast(cmfb_fast), .h_count(h_count), .v_count(v_count),
        .busy(busy), .in_init(in_init)
    );
endmodule

// File: tb/cs_acq_seq_test.sv
`timescale 1ns/1ps
module cs_acq_seq_test;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int CELLS = ROWS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] meas_count = '0;
    logic ss_en, coef_bit, hs_en, vs_en, adc_sample, cmfb_fast, busy, in_init;
    logic [3:0] h_count, v_count;

    always #2 clk = ~clk;

    cs_acq_seq #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .meas_count(meas_count),
        .ss_en(ss_en), .coef_bit(coef_bit), .hs_en(hs_en), .vs_en(vs_en),
        .adc_sample(adc_sample), .cmfb_fast(cmfb_fast), .h_count(h_count),
        .v_count(v_count), .busy(busy), .in_init(in_init)
    );

    typedef struct {
        logic ss, coef, hs, vs, adc, bsy, init;
        logic [3:0] hc, vc;
        string tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit mon_on = 0;
    bit done = 0;
    string idle_tag = "R1";
    logic [15:0] ser_m = 16'hACE1;
    logic [7:0] hs_m = 8'h01;
    logic [7:0] vs_m = 8'hB4;
    logic [3:0] exp_h = 0, exp_v = 0;
    bit seeded_m = 0;
    int hzero = 0, vzero = 0;

    function automatic logic [15:0] ser_next(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
    function automatic logic [7:0] sh_next(logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic item_t mk(logic ss, logic coef, logic hs, logic vs, logic adc,
                                 logic init, string tag);
        item_t it;
        it.ss = ss; it.coef = coef; it.hs = hs; it.vs = vs; it.adc = adc;
        it.bsy = 1'b1; it.init = init; it.hc = exp_h; it.vc = exp_v; it.tag = tag;
        return it;
    endfunction

    // monitor: pops one expected item per cycle, idle expectation when empty
    always begin
        @(posedge clk);
        #1;
        if (mon_on) begin
            item_t it;
            if (q.size() > 0) it = q.pop_front();
            else begin
                it.ss = 0; it.coef = 0; it.hs = 0; it.vs = 0; it.adc = 0;
                it.bsy = 0; it.init = 0; it.hc = exp_h; it.vc = exp_v; it.tag = idle_tag;
            end
            chk(it.tag, "ss_en", int'(ss_en), int'(it.ss));
            if (it.ss) chk(it.tag, "coef_bit", int'(coef_bit), int'(it.coef));
            chk(it.tag, "hs_en", int'(hs_en), int'(it.hs));
            chk(it.tag, "vs_en", int'(vs_en), int'(it.vs));
            chk(it.tag, "adc_sample", int'(adc_sample), int'(it.adc));
            chk("R4", "cmfb_fast", int'(cmfb_fast), int'(it.adc));
            chk(it.tag, "busy", int'(busy), int'(it.bsy));
            chk(it.tag, "in_init", int'(in_init), int'(it.init));
            chk(it.tag, "h_count", int'(h_count), int'(it.hc));
            chk(it.tag, "v_count", int'(v_count), int'(it.vc));
            chk("R9", "enables onehot", int'($countones({ss_en, hs_en, vs_en, adc_sample}) <= 1), 1);
        end
    end

    // driver: called right after a negedge while the design is idle
    task automatic observe(int m, bit disturb);
        if (m == 0) begin
            idle_tag = "R8";
            start = 1; meas_count = 0;
            @(negedge clk); start = 0;
            repeat (3) @(negedge clk);
            idle_tag = "R7";
            return;
        end
        if (!seeded_m) begin
            for (int i = 0; i < CELLS; i++) begin
                q.push_back(mk(1, ser_m[0], 0, 0, 0, 1, "R2"));
                ser_m = ser_next(ser_m);
            end
            seeded_m = 1;
        end else begin
            logic [3:0] h, v;
            string tg;
            h = hs_m[3:0]; v = vs_m[3:0];
            hs_m = sh_next(hs_m); vs_m = sh_next(vs_m);
            exp_h = h; exp_v = v;
            if (h == 0) hzero++;
            if (v == 0) vzero++;
            tg = (h == 0 || v == 0) ? "R6" : "R5";
            for (int i = 0; i < int'(h); i++) q.push_back(mk(0, 0, 1, 0, 0, 0, tg));
            for (int i = 0; i < int'(v); i++) q.push_back(mk(0, 0, 0, 1, 0, 0, tg));
            if (h == 0 && v == 0) q.push_back(mk(1, ser_m[0], 0, 0, 0, 0, "R6"));
            else q.push_back(mk(1, ser_m[0], 0, 0, 0, 0, "R3"));
            ser_m = ser_next(ser_m);
            q.push_back(mk(0, 0, 0, 0, 1, 0, "R3"));
            m = m - 1;
        end
        for (int k = 0; k < m; k++) begin
            q.push_back(mk(1, ser_m[0], 0, 0, 0, 0, "R3"));
            ser_m = ser_next(ser_m);
            q.push_back(mk(0, 0, 0, 0, 1, 0, "R3"));
        end
        start = 1; meas_count = 16'(m + (seeded_m && q.size() > 0 ? 0 : 0));
        meas_count = 16'(m);
        if (!(q.size() > 0 && q[0].init)) meas_count = 16'(m + 1);
        @(negedge clk); start = 0;
        if (disturb) begin
            meas_count = 16'(m + 7);   // R7: changed in mid-observation
            @(negedge clk); start = 1; // R7: start while busy
            @(negedge clk); start = 0;
        end
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "ss_en in reset", int'(ss_en), 0);
        chk("R1", "adc_sample in reset", int'(adc_sample), 0);
        chk("R1", "h_count in reset", int'(h_count), 0);
        rst_n = 1;
        mon_on = 1;
        repeat (3) @(negedge clk);
        idle_tag = "R7";
        observe(0, 0);          // R8 before any fill
        observe(3, 1);          // R2 fill then R3 pairs, R7 disturbance
        observe(1, 0);
        observe(4, 1);
        observe(0, 0);          // R8 after fill
        for (int i = 0; i < 256; i++) observe(1 + (i % 3), (i % 5) == 0);
        chk("R6", "zero horizontal count seen", int'(hzero > 0), 1);
        chk("R6", "zero vertical count seen", int'(vzero > 0), 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule